// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a multiplexed register port that gives direct access to a flash array's control pins. It accepts one command at a time: a single-byte read, a row program, a page erase or a mass erase. For each command it emits the ordered series of register writes (a 3-bit select plus an 8-bit data byte, qualified by a one-cycle write strobe) and holds every required delay using one shared down-counter. The delays are given in microseconds and converted to clock cycles through a cycles-per-microsecond parameter.

A row program takes a start byte address, a byte count and a stream of data bytes. The program and store controls stay asserted for the whole row. Only the byte-enable control is pulsed once per byte while the column address steps. Before any port activity, a requested row is checked against the row boundary and against a cumulative high-voltage budget. A read drives the address, enables the array outputs, waits an access time, then switches the port to the output register and captures the byte. The block raises `busy` for the duration of a command and pulses `done` at its end, with `err` when the request was refused.

Top module: `fbs_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `bp_wr`, `bp_drive` and `data_take` are all low.
- R2: A command (`cmd_valid` high) is taken only while `busy` is low. A command presented while busy causes no port write and does not change the running sequence.
- R3: A row program writes, in order: select 4 = {TMR=1 (bit 7), info (bit 6), 0}, select 0 = address[15:8], select 1 = address[7:0], select 3 = 0x84, select 3 = 0x85. Then, per byte: select 1 = current byte address, select 2 = data, select 3 = 0xC5, select 3 = 0x85. It finishes with select 3 = 0x81 and select 3 = 0x00. Control byte bits, MSB first, are: XE, YE, SE, OE, ERASE, PROG, MAS1, NVSTR.
- R4: Between register writes, the block keeps at least these gaps: NVS_US after 0x84, PGS_US after the 0x85 that starts programming, PROG_US after each 0xC5, NVH_US after 0x81. It also keeps RCV_US between the final 0x00 and `done`. Every gap is multiplied by CYC_PER_US cycles.
- R5: During a program, the row part of the address never changes. The column address starts at address[Y-1:0] and rises by one per byte. No select-0 write occurs while PROG and NVSTR are both set.
- R6: A program request is refused when its count is 0, when start column + count exceeds ROW_BYTES, or when count × PROG_US exceeds HV_MAX_US. A refused request makes no port write and gives `done` with `err` two cycles after acceptance.
- R7: A page erase (op 2) writes select 4, select 0 and select 1 as in R3. It then writes select 3 = 0x88 (wait NVS_US), 0x89 (wait ERASE_US), 0x81 (wait NVH_US) and 0x00 (wait RCV_US).
- R8: A mass erase (op 3) follows the same pattern with 0x8A (wait NVS_US), 0x8B (wait ME_US), 0x81 (wait NVH_ME_US) and 0x00 (wait RCV_US).
- R9: A read (op 0) writes select 4, select 0 and select 1, then select 3 = 0xF0, holding it at least ACC_CYC cycles. It then sets select 5 with `bp_drive` low, captures `bp_din` into `rd_data`, and writes select 3 = 0x00.
- R10: `busy` is high from the cycle after acceptance until the cycle of `done`. `done` is a single-cycle pulse, and `err` is low on every completed command.
- R11: `data_take` pulses exactly once per programmed byte, in the same cycle as the select-2 write that carries that byte.
- R12: The info bit of the command appears as bit 6 of the select-4 write, and it selects the information area for every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 read, 1 row program, 2 page erase, 3 mass erase |
| cmd_addr | input | 16 | Byte address (row in upper bits, column in lower bits) |
| cmd_count | input | $clog2(ROW_BYTES+1) | Bytes to program |
| cmd_info | input | 1 | Select information area |
| wr_data | input | 8 | Current program data byte, held until `data_take` |
| data_take | output | 1 | Current data byte was consumed |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused (with `done`) |
| rd_data | output | 8 | Byte captured by the last read |
| bp_sel | output | 3 | Register select on the bypass port |
| bp_dout | output | 8 | Data written to the selected register |
| bp_drive | output | 1 | Host drives the data lines |
| bp_wr | output | 1 | One-cycle register write strobe |
| bp_din | input | 8 | Data lines read back while select 5 is set |

## Verification
The bench models the flash-side register file. It predicts every register write of each command and compares both select and data, so a wrong control constant, a swapped step or a missing byte iteration shows up as a mismatch on the first affected write. Spacing between writes is measured against the microsecond minimums, which catches a design that loads the wrong wait or skips the recovery time before `done`. Program requests are placed exactly at the row end and exactly at the high-voltage budget, and one past each: a design off by one in either check would refuse a legal row or run an illegal one. A second command is injected mid-erase, where a design that does not gate acceptance would start writing address bytes in the middle of the erase.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_PROG   = 2'd1,
    OP_PERASE = 2'd2,
    OP_MERASE = 2'd3
  } fbs_op_e;

  // register selects on the bypass port
  localparam logic [2:0] SEL_AHI = 3'd0;
  localparam logic [2:0] SEL_ALO = 3'd1;
  localparam logic [2:0] SEL_DAT = 3'd2;
  localparam logic [2:0] SEL_CTL = 3'd3;
  localparam logic [2:0] SEL_TST = 3'd4;
  localparam logic [2:0] SEL_OUT = 3'd5;

  // control byte bits
  localparam logic [7:0] CTL_XE    = 8'h80;
  localparam logic [7:0] CTL_YE    = 8'h40;
  localparam logic [7:0] CTL_SE    = 8'h20;
  localparam logic [7:0] CTL_OE    = 8'h10;
  localparam logic [7:0] CTL_ERASE = 8'h08;
  localparam logic [7:0] CTL_PROG  = 8'h04;
  localparam logic [7:0] CTL_BULK  = 8'h02;
  localparam logic [7:0] CTL_NV    = 8'h01;

  localparam int unsigned STEP_W    = 4;
  localparam logic [3:0]  LOOP_STEP = 4'd5;
  localparam int unsigned ADDR_W    = 16;

endpackage

// File: rtl/fbs_wait_timer.sv
module fbs_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

  // R4: a counting wait never jumps straight to zero from a large value
  p_no_skip_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt > 2) |=> !zero);

endmodule

// File: rtl/fbs_step_rom.sv
module fbs_step_rom
  import fbs_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 50,
  parameter int unsigned NVS_US     = 5,
  parameter int unsigned PGS_US     = 10,
  parameter int unsigned PROG_US    = 40,
  parameter int unsigned NVH_US     = 5,
  parameter int unsigned NVH_ME_US  = 100,
  parameter int unsigned RCV_US     = 1,
  parameter int unsigned ERASE_US   = 10000,
  parameter int unsigned ME_US      = 200000,
  parameter int unsigned ACC_CYC    = 3,
  parameter int unsigned CNT_W      = 24
) (
  input  fbs_op_e           op,
  input  logic [STEP_W-1:0] step,
  input  logic              info,
  input  logic [7:0]        addr_hi,
  input  logic [7:0]        lo_cur,
  input  logic [7:0]        data_b,
  output logic [2:0]        st_sel,
  output logic [7:0]        st_val,
  output logic              st_obs,
  output logic [CNT_W-1:0]  st_wait,
  output logic              st_last,
  output logic              st_loop,
  output logic              st_take
);

  localparam logic [CNT_W-1:0] W_NVS  = CNT_W'(NVS_US * CYC_PER_US);
  localparam logic [CNT_W-1:0] W_PGS  = CNT_W'(PGS_US * CYC_PER_US);
  localparam logic [CNT_W-1:0] W_PROG = CNT_W'(PROG_US * CYC_PER_US);
  localparam logic [CNT_W-1:0] W_NVH  = CNT_W'(NVH_US * CYC_PER_US);
  localparam logic [CNT_W-1:0] W_NVH1 = CNT_W'(NVH_ME_US * CYC_PER_US);
  localparam logic [CNT_W-1:0] W_RCV  = CNT_W'(RCV_US * CYC_PER_US);
  localparam logic [CNT_W-1:0] W_ERS  = CNT_W'(ERASE_US * CYC_PER_US);
  localparam logic [CNT_W-1:0] W_ME   = CNT_W'(ME_US * CYC_PER_US);
  localparam logic [CNT_W-1:0] W_ACC  = CNT_W'(ACC_CYC);
  localparam logic [CNT_W-1:0] W_ONE  = CNT_W'(1);

  logic       bulk;
  logic [7:0] ers_base;

  assign bulk     = (op == OP_MERASE);
  assign ers_base = CTL_XE | CTL_ERASE | (bulk ? CTL_BULK : 8'h00);

  always_comb begin
    st_sel  = SEL_CTL;
    st_val  = 8'h00;
    st_obs  = 1'b0;
    st_wait = '0;
    st_last = 1'b0;
    st_loop = 1'b0;
    st_take = 1'b0;
    case (step)
      4'd0: begin st_sel = SEL_TST; st_val = {1'b1, info, 6'b0}; end
      4'd1: begin st_sel = SEL_AHI; st_val = addr_hi; end
      4'd2: begin st_sel = SEL_ALO; st_val = lo_cur; end
      default: begin
        case (op)
          OP_READ: begin
            case (step)
              4'd3: begin st_val = CTL_XE | CTL_YE | CTL_SE | CTL_OE; st_wait = W_ACC; end
              4'd4: begin st_sel = SEL_OUT; st_obs = 1'b1; st_wait = W_ONE; end
              default: begin st_val = 8'h00; st_last = 1'b1; end
            endcase
          end
          OP_PROG: begin
            case (step)
              4'd3:  begin st_val = CTL_XE | CTL_PROG; st_wait = W_NVS; end
              4'd4:  begin st_val = CTL_XE | CTL_PROG | CTL_NV; st_wait = W_PGS; end
              4'd5:  begin st_sel = SEL_ALO; st_val = lo_cur; end
              4'd6:  begin st_sel = SEL_DAT; st_val = data_b; st_take = 1'b1; end
              4'd7:  begin st_val = CTL_XE | CTL_YE | CTL_PROG | CTL_NV; st_wait = W_PROG; end
              4'd8:  begin st_val = CTL_XE | CTL_PROG | CTL_NV; st_loop = 1'b1; end
              4'd9:  begin st_val = CTL_XE | CTL_NV; st_wait = W_NVH; end
              default: begin st_val = 8'h00; st_wait = W_RCV; st_last = 1'b1; end
            endcase
          end
          default: begin
            case (step)
              4'd3: begin st_val = ers_base; st_wait = W_NVS; end
              4'd4: begin st_val = ers_base | CTL_NV; st_wait = bulk ? W_ME : W_ERS; end
              4'd5: begin st_val = CTL_XE | CTL_NV; st_wait = bulk ? W_NVH1 : W_NVH; end
              default: begin st_val = 8'h00; st_wait = W_RCV; st_last = 1'b1; end
            endcase
          end
        endcase
      end
    endcase
  end

endmodule

// File: rtl/fbs_seq.sv
module fbs_seq
  import fbs_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 50,
  parameter int unsigned ROW_BYTES  = 64,
  parameter int unsigned NVS_US     = 5,
  parameter int unsigned PGS_US     = 10,
  parameter int unsigned PROG_US    = 40,
  parameter int unsigned NVH_US     = 5,
  parameter int unsigned NVH_ME_US  = 100,
  parameter int unsigned RCV_US     = 1,
  parameter int unsigned ERASE_US   = 10000,
  parameter int unsigned ME_US      = 200000,
  parameter int unsigned HV_MAX_US  = 12000,
  parameter int unsigned ACC_CYC    = 3,
  localparam int unsigned CNT_IN_W  = $clog2(ROW_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [CNT_IN_W-1:0] cmd_count,
  input  logic                cmd_info,
  input  logic [7:0]          wr_data,
  output logic                data_take,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [7:0]          rd_data,
  output logic [2:0]          bp_sel,
  output logic [7:0]          bp_dout,
  output logic                bp_drive,
  output logic                bp_wr,
  input  logic [7:0]          bp_din
);

  localparam int unsigned Y_W     = $clog2(ROW_BYTES);
  localparam int unsigned BIG_US  = (ME_US > ERASE_US) ? ME_US : ERASE_US;
  localparam int unsigned MAX_CYC = (BIG_US + PROG_US + NVH_ME_US) * CYC_PER_US + ACC_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_REJ} state_e;

  state_e              state;
  fbs_op_e             op_q;
  logic                info_q;
  logic [7:0]          ahi_q;
  logic [7:0]          lo_q;
  logic [CNT_IN_W-1:0] left_q;
  logic [STEP_W-1:0]   step_q;
  logic                obs_q, last_q, loop_q;

  logic [2:0]       st_sel;
  logic [7:0]       st_val;
  logic             st_obs, st_last, st_loop, st_take;
  logic [CNT_W-1:0] st_wait;
  logic             tmr_zero;

  // request screening for row programs
  logic [31:0] span, hv_us;
  logic        bad_req;

  always_comb begin
    span    = 32'(cmd_addr[Y_W-1:0]) + 32'(cmd_count);
    hv_us   = 32'(cmd_count) * PROG_US;
    bad_req = (cmd_count == '0) || (span > ROW_BYTES) || (hv_us > HV_MAX_US);
  end

  fbs_step_rom #(
    .CYC_PER_US(CYC_PER_US), .NVS_US(NVS_US), .PGS_US(PGS_US), .PROG_US(PROG_US),
    .NVH_US(NVH_US), .NVH_ME_US(NVH_ME_US), .RCV_US(RCV_US), .ERASE_US(ERASE_US),
    .ME_US(ME_US), .ACC_CYC(ACC_CYC), .CNT_W(CNT_W)
  ) u_rom (
    .op(op_q), .step(step_q), .info(info_q), .addr_hi(ahi_q), .lo_cur(lo_q),
    .data_b(wr_data), .st_sel(st_sel), .st_val(st_val), .st_obs(st_obs),
    .st_wait(st_wait), .st_last(st_last), .st_loop(st_loop), .st_take(st_take)
  );

  fbs_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(state == S_ISSUE), .load_val(st_wait), .zero(tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      bp_wr     <= 1'b0;
      bp_drive  <= 1'b0;
      data_take <= 1'b0;
      bp_sel    <= 3'd0;
      bp_dout   <= 8'h00;
      rd_data   <= 8'h00;
      op_q      <= OP_READ;
      info_q    <= 1'b0;
      ahi_q     <= 8'h00;
      lo_q      <= 8'h00;
      left_q    <= '0;
      step_q    <= '0;
      obs_q     <= 1'b0;
      last_q    <= 1'b0;
      loop_q    <= 1'b0;
    end else begin
      done      <= 1'b0;
      err       <= 1'b0;
      bp_wr     <= 1'b0;
      data_take <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            op_q   <= fbs_op_e'(cmd_op);
            info_q <= cmd_info;
            ahi_q  <= cmd_addr[15:8];
            lo_q   <= cmd_addr[7:0];
            left_q <= cmd_count;
            step_q <= '0;
            busy   <= 1'b1;
            state  <= (fbs_op_e'(cmd_op) == OP_PROG && bad_req) ? S_REJ : S_ISSUE;
          end
        end
        S_ISSUE: begin
          bp_sel    <= st_sel;
          bp_dout   <= st_val;
          bp_wr     <= !st_obs;
          bp_drive  <= !st_obs;
          data_take <= st_take;
          obs_q     <= st_obs;
          last_q    <= st_last;
          loop_q    <= st_loop;
          state     <= S_WAIT;
        end
        S_WAIT: begin
          if (tmr_zero) begin
            if (obs_q) rd_data <= bp_din;
            if (last_q) begin
              done     <= 1'b1;
              busy     <= 1'b0;
              bp_drive <= 1'b0;
              state    <= S_IDLE;
            end else begin
              if (loop_q && left_q > 1) begin
                left_q         <= left_q - 1'b1;
                lo_q[Y_W-1:0]  <= lo_q[Y_W-1:0] + 1'b1;
                step_q         <= LOOP_STEP;
              end else begin
                step_q <= step_q + 1'b1;
              end
              state <= S_ISSUE;
            end
          end
        end
        default: begin
          done  <= 1'b1;
          err   <= 1'b1;
          busy  <= 1'b0;
          state <= S_IDLE;
        end
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!bp_wr && !data_take));

  p_ignore_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> ($stable(op_q) && $stable(ahi_q)));

  p_spaced_writes_r4: assert property (@(posedge clk) disable iff (rst)
    bp_wr |=> !bp_wr);

  p_row_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(lo_q[7:Y_W]) && $stable(ahi_q)));

  p_err_with_done_r6: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_take_on_data_r11: assert property (@(posedge clk) disable iff (rst)
    data_take |-> (bp_wr && bp_sel == SEL_DAT));

endmodule

// File: tb/fbs_seq_test.sv
module fbs_seq_test;

  localparam int C      = 2;
  localparam int NVS    = 5;
  localparam int PGS    = 10;
  localparam int PRG    = 40;
  localparam int NVH    = 5;
  localparam int NVH1   = 100;
  localparam int RCV    = 1;
  localparam int ERS    = 2000;
  localparam int MER    = 5000;
  localparam int HVMAX  = 400;
  localparam int ACC    = 3;

  logic       clk = 1'b0;
  logic       rst;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic [15:0] cmd_addr;
  logic [6:0] cmd_count;
  logic       cmd_info;
  logic [7:0] wr_data;
  logic       data_take, busy, done, err;
  logic [7:0] rd_data;
  logic [2:0] bp_sel;
  logic [7:0] bp_dout;
  logic       bp_drive, bp_wr;
  logic [7:0] bp_din;

  always #10 clk = ~clk;

  fbs_seq #(
    .CYC_PER_US(C), .ROW_BYTES(64), .NVS_US(NVS), .PGS_US(PGS), .PROG_US(PRG),
    .NVH_US(NVH), .NVH_ME_US(NVH1), .RCV_US(RCV), .ERASE_US(ERS), .ME_US(MER),
    .HV_MAX_US(HVMAX), .ACC_CYC(ACC)
  ) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_count(cmd_count), .cmd_info(cmd_info), .wr_data(wr_data), .data_take(data_take),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data), .bp_sel(bp_sel),
    .bp_dout(bp_dout), .bp_drive(bp_drive), .bp_wr(bp_wr), .bp_din(bp_din)
  );

  typedef struct packed {
    logic [2:0]  s;
    logic [7:0]  v;
    logic [31:0] w;
  } ent_t;

  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  ent_t expq[$];
  int   last_wr_cyc = 0;
  int   last_w = 0;
  int   writes_cmd = 0;
  int   takes = 0;
  int   didx = 0;
  int   done_cnt = 0;
  int   done_cyc = 0;
  logic done_err_seen = 1'b0;
  logic exp_busy = 1'b0;
  logic [7:0] darr [0:63];
  logic [7:0] reg_ahi = 8'h00, reg_alo = 8'h00, reg_ctl = 8'h00, reg_tst = 8'h00;

  function automatic logic [7:0] mem_byte(input logic [7:0] hi, input logic [7:0] lo,
                                          input logic inf);
    return hi ^ {lo[3:0], lo[7:4]} ^ (inf ? 8'hA5 : 8'h00);
  endfunction

  assign bp_din  = (bp_sel == 3'd5) ? mem_byte(reg_ahi, reg_alo, reg_tst[6]) : 8'h00;
  assign wr_data = darr[6'(didx)];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic void push(input logic [2:0] s, input logic [7:0] v, input int w);
    ent_t e;
    e.s = s; e.v = v; e.w = 32'(w);
    expq.push_back(e);
  endfunction

  // flash-side register model and per-clock comparison
  always @(negedge clk) begin
    ent_t e;
    cyc++;
    if (!rst) begin
      if (done) exp_busy = 1'b0;
      chk(busy === exp_busy, "R10", "busy", int'(busy), int'(exp_busy));
      if (data_take) begin
        takes++;
        chk(bp_wr && bp_sel == 3'd2, "R11", "take without data write", int'(bp_sel), 2);
        didx++;
      end
      if (bp_wr) begin
        writes_cmd++;
        if (expq.size() == 0) begin
          chk(1'b0, "R2", "unexpected write sel", int'(bp_sel), 0);
        end else begin
          e = expq.pop_front();
          chk(bp_sel == e.s, "R3", "select", int'(bp_sel), int'(e.s));
          chk(bp_dout == e.v, "R3", "data", int'(bp_dout), int'(e.v));
          if (writes_cmd > 1)
            chk(cyc - last_wr_cyc >= last_w, "R4", "gap", cyc - last_wr_cyc, last_w);
          last_w      = int'(e.w);
          last_wr_cyc = cyc;
        end
        if (bp_sel == 3'd0)
          chk(!(reg_ctl[2] && reg_ctl[0]), "R5", "row write while storing", int'(reg_ctl), 0);
        case (bp_sel)
          3'd0: reg_ahi = bp_dout;
          3'd1: reg_alo = bp_dout;
          3'd3: reg_ctl = bp_dout;
          3'd4: reg_tst = bp_dout;
          default: ;
        endcase
      end
      if (busy && bp_sel == 3'd5)
        chk(!bp_drive, "R9", "driving during output select", int'(bp_drive), 0);
      if (done) begin
        done_cnt++;
        done_err_seen = err;
        done_cyc = cyc;
      end
    end
  end

  task automatic run(input logic [1:0] op, input logic [15:0] addr, input int cnt,
                     input logic inf, input bit exp_err, input bit poke);
    int n0;
    logic [7:0] exp_rd;
    expq.delete();
    writes_cmd = 0; takes = 0; didx = 0; last_w = 0;
    for (int k = 0; k < 64; k++) darr[k] = 8'(8'h30 + k * 7 + int'(addr[3:0]));
    if (!exp_err) begin
      push(3'd4, {1'b1, inf, 6'b0}, 0);
      push(3'd0, addr[15:8], 0);
      push(3'd1, addr[7:0], 0);
      case (op)
        2'd0: begin push(3'd3, 8'hF0, ACC); push(3'd3, 8'h00, 0); end
        2'd1: begin
          push(3'd3, 8'h84, NVS * C);
          push(3'd3, 8'h85, PGS * C);
          for (int k = 0; k < cnt; k++) begin
            push(3'd1, {addr[7:6], 6'(int'(addr[5:0]) + k)}, 0);
            push(3'd2, darr[k], 0);
            push(3'd3, 8'hC5, PRG * C);
            push(3'd3, 8'h85, 0);
          end
          push(3'd3, 8'h81, NVH * C);
          push(3'd3, 8'h00, RCV * C);
        end
        2'd2: begin
          push(3'd3, 8'h88, NVS * C); push(3'd3, 8'h89, ERS * C);
          push(3'd3, 8'h81, NVH * C); push(3'd3, 8'h00, RCV * C);
        end
        default: begin
          push(3'd3, 8'h8A, NVS * C); push(3'd3, 8'h8B, MER * C);
          push(3'd3, 8'h81, NVH1 * C); push(3'd3, 8'h00, RCV * C);
        end
      endcase
    end
    exp_rd = mem_byte(addr[15:8], addr[7:0], inf);
    n0 = done_cnt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_count = 7'(cnt); cmd_info = inf;
    @(posedge clk);
    #1 exp_busy = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op ^ 2'b01; cmd_addr = ~addr; cmd_count = 7'd1;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    wait (done_cnt != n0);
    chk(done_err_seen == exp_err, "R6", "err at done", int'(done_err_seen), int'(exp_err));
    chk(expq.size() == 0, "R3", "writes left over", expq.size(), 0);
    if (exp_err) begin
      chk(writes_cmd == 0, "R6", "writes on refused request", writes_cmd, 0);
    end else begin
      chk(done_cyc - last_wr_cyc >= last_w, "R4", "recovery before done",
          done_cyc - last_wr_cyc, last_w);
      if (op == 2'd1) chk(takes == cnt, "R11", "data takes", takes, cnt);
      if (op == 2'd0) chk(rd_data == exp_rd, "R9", "read data", int'(rd_data), int'(exp_rd));
    end
    @(negedge clk);
    chk(!done, "R10", "done longer than one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired act=%0d exp=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_addr = 16'h0; cmd_count = 7'd0;
    cmd_info = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err, "R1", "status after reset", int'({busy, done, err}), 0);
    chk(!bp_wr && !bp_drive && !data_take, "R1", "port after reset",
        int'({bp_wr, bp_drive, data_take}), 0);
    // R9 read of main area, R12 info read
    run(2'd0, 16'h1234, 0, 1'b0, 1'b0, 1'b0);
    run(2'd0, 16'h0A7F, 0, 1'b1, 1'b0, 1'b0);
    // R3 R5 R11 program ending exactly on the row edge
    run(2'd1, 16'h0A3C, 4, 1'b0, 1'b0, 1'b0);
    // R6 one past the row edge
    run(2'd1, 16'h0A3D, 4, 1'b0, 1'b1, 1'b0);
    // R6 budget: 10 bytes fits exactly, 11 exceeds
    run(2'd1, 16'h5500, 10, 1'b1, 1'b0, 1'b0);
    run(2'd1, 16'h5500, 11, 1'b0, 1'b1, 1'b0);
    // R6 zero count
    run(2'd1, 16'h0040, 0, 1'b0, 1'b1, 1'b0);
    // R7 page erase with a command injected while busy (R2)
    run(2'd2, 16'h3300, 0, 1'b1, 1'b0, 1'b1);
    // R8 mass erase, also poked while busy
    run(2'd3, 16'h0000, 0, 1'b0, 1'b0, 1'b1);
    // single-byte program then read back path
    run(2'd1, 16'h7F05, 1, 1'b0, 1'b0, 1'b1);
    run(2'd0, 16'h7F05, 0, 1'b0, 1'b0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule